// File: doc/BRIEF.md
# Pulsed Output Strobe Generator

This block drives the output handshake strobe of a double-buffered output port. The buffer logic raises `data_ready` for one or more cycles when the output buffer holds data for the peripheral. The block then asserts the strobe as a pulse of at most `PULSE_CYCLES` clocks, which is four by default. When nothing interrupts it, the pulse runs the full length. The peripheral answers on a companion input handshake line. An asserted edge on that line, seen while the pulse is active, removes the strobe at once without waiting for a clock edge. One registered copy of the line, corrected for polarity, provides the previous value for edge detection.

A single polarity bit, `pin_sense`, sets the meaning of both pins. At 0 the asserted level is low, and at 1 it is high. When the port enable is low, the strobe is held negated, any pulse in flight is aborted and pending requests are dropped. A request that arrives during a pulse is held until that pulse ends, so back-to-back pulses are always separated by one negated cycle. The status output for this strobe is always zero in this mode. A level output mirrors the pin.

The controller has three states:
- `ST_OFF`: port disabled. It moves to `ST_IDLE` when `port_en` is 1.
- `ST_IDLE`: enabled and waiting. It moves to `ST_PULSE` on `data_ready` or a pending request.
- `ST_PULSE`: strobe active. It returns to `ST_IDLE` after the last count or on an input edge.

Any state goes to `ST_OFF` when `port_en` is 0. Reset also enters `ST_OFF`.

Top module: `hs_pulse_strobe`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the strobe is negated. The pin equals the inverse of `pin_sense`.
- R2: With the port enabled and idle, a `data_ready` sampled at a rising edge asserts the strobe from that edge for exactly `PULSE_CYCLES` (4) cycles, after which it is negated.
- R3: An asserted edge on `ack_pin` during an active pulse negates the strobe combinationally in the same cycle. The strobe then stays negated for the rest of that pulse.
- R4: A `data_ready` that arrives during a pulse, or in the cycle right after one, starts a new full pulse. That pulse begins after exactly one negated cycle.
- R5: While `port_en` is 0, the strobe is negated immediately. An active pulse is aborted. Requests seen while disabled are discarded and produce no pulse after the port is enabled again.
- R6: With `pin_sense` = 0, the asserted level of `strobe_pin` and `ack_pin` is 0. With `pin_sense` = 1, it is 1.
- R7: `strobe_status` reads 0 in every cycle.
- R8: `strobe_level` always equals the current level of `strobe_pin`.
- R9: Only a transition of `ack_pin` from negated to asserted counts as an edge. A line that is already asserted when a pulse starts does not shorten it. An edge while idle has no effect on the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port handshake enable |
| pin_sense | input | 1 | Pin polarity: 0 means asserted low |
| ack_pin | input | 1 | Companion input handshake line |
| data_ready | input | 1 | Output buffer has data for the peripheral |
| strobe_pin | output | 1 | Pulsed output handshake strobe |
| strobe_status | output | 1 | Status bit of the strobe, always 0 |
| strobe_level | output | 1 | Instantaneous level of the strobe pin |

## Verification
Inputs change just after a falling edge, and outputs are sampled 1 ns later, in the same low half-cycle. A request driven in half-cycle 0 produces an asserted strobe in samples 1 to 4. Killing, disabling and the status and level outputs are combinational, so they are checked in the same sample in which their input changed. A request held over a pulse is expected in samples 6 to 9. The sweeps cover both polarities, every kill position from sample 1 to sample 5, and every deferral position from sample 1 to sample 5. Each expected value comes from these sample-index formulas and not from a model of the design.

// File: rtl/hs_pulse_pkg.sv
package hs_pulse_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PULSE = 2'd2
    } hs_state_e;

endpackage

// File: rtl/hs_edge_detect.sv
module hs_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_pin,
    input  logic sense,
    output logic line_asserted,
    output logic line_rise
);

    logic prev_q;

    // Polarity corrected view of the line: asserted when pin equals sense (R6)
    assign line_asserted = ~(line_pin ^ sense);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_asserted;
        end
    end

    // Combinational asserted edge against the registered copy (R9)
    assign line_rise = line_asserted & ~prev_q;

endmodule

// File: rtl/hs_pulse_fsm.sv
module hs_pulse_fsm
    import hs_pulse_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic trigger,
    input  logic abort,
    output logic pulse_on
);

    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_CYCLES - 1);

    hs_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q | trigger;
        unique case (state_q)
            ST_OFF: begin
                cnt_d  = '0;
                pend_d = 1'b0;
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                cnt_d = '0;
                if (trigger || pend_q) begin
                    state_d = ST_PULSE;
                    pend_d  = 1'b0;
                end
            end
            ST_PULSE: begin
                if (abort || (cnt_q == LAST_CNT)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_d   = '0;
                pend_d  = 1'b0;
            end
        endcase
        if (!port_en) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            pend_d  = 1'b0;
        end
    end

    // Outputs
    always_comb begin
        pulse_on = (state_q == ST_PULSE);
    end

endmodule

// File: rtl/hs_pulse_strobe.sv
module hs_pulse_strobe #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic pin_sense,
    input  logic ack_pin,
    input  logic data_ready,
    output logic strobe_pin,
    output logic strobe_status,
    output logic strobe_level
);

    logic ack_asserted;
    logic ack_rise;
    logic pulse_on;
    logic strobe_asserted;

    hs_edge_detect u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_pin      (ack_pin),
        .sense         (pin_sense),
        .line_asserted (ack_asserted),
        .line_rise     (ack_rise)
    );

    hs_pulse_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (port_en),
        .trigger  (data_ready),
        .abort    (ack_rise),
        .pulse_on (pulse_on)
    );

    // Enable gating and early kill are combinational (R3, R5)
    assign strobe_asserted = pulse_on & port_en & ~ack_rise;
    assign strobe_pin      = ~(strobe_asserted ^ pin_sense);
    assign strobe_status   = 1'b0;
    assign strobe_level    = strobe_pin;

endmodule

// File: rtl/hs_pulse_strobe_chk.sv
module hs_pulse_strobe_chk #(
    parameter int PULSE_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic pin_sense,
    input logic ack_pin,
    input logic strobe_pin
);

    localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

    logic             on_w;
    logic             ack_w;
    logic [RUN_W-1:0] run_q;

    assign on_w  = (strobe_pin == pin_sense);
    assign ack_w = (ack_pin == pin_sense);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!on_w) begin
            run_q <= '0;
        end else if (run_q <= RUN_W'(PULSE_CYCLES)) begin
            run_q <= run_q + 1'b1;
        end
    end

    a_r1_negated_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !on_w);

    a_r2_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(PULSE_CYCLES));

    a_r3_edge_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && !$past(ack_w)) |-> !on_w);

    a_r5_disabled_negated: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !on_w);

endmodule

bind hs_pulse_strobe hs_pulse_strobe_chk #(
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .pin_sense  (pin_sense),
    .ack_pin    (ack_pin),
    .strobe_pin (strobe_pin)
);

// File: tb/hs_pulse_strobe_tb.sv
`timescale 1ns/100ps
module hs_pulse_strobe_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b1;
    logic pin_sense = 1'b0;
    logic ack_pin = 1'b1;
    logic data_ready = 1'b0;
    logic strobe_pin, strobe_status, strobe_level;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hs_pulse_strobe #(.PULSE_CYCLES(4)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_en       (port_en),
        .pin_sense     (pin_sense),
        .ack_pin       (ack_pin),
        .data_ready    (data_ready),
        .strobe_pin    (strobe_pin),
        .strobe_status (strobe_status),
        .strobe_level  (strobe_level)
    );

    task automatic chk(input bit exp_on, input string req, input int n);
        logic exp_pin;
        exp_pin = exp_on ? pin_sense : ~pin_sense;
        tests++;
        if (strobe_pin !== exp_pin) begin
            fails++;
            $display("FAIL %s strobe_pin sample %0d sense %0b: got %b exp %b",
                     req, n, pin_sense, strobe_pin, exp_pin);
        end
        tests++;
        if (strobe_status !== 1'b0) begin // R7
            fails++;
            $display("FAIL R7 strobe_status sample %0d: got %b exp 0", n, strobe_status);
        end
        tests++;
        if (strobe_level !== strobe_pin) begin // R8
            fails++;
            $display("FAIL R8 strobe_level sample %0d: got %b exp %b", n, strobe_level, strobe_pin);
        end
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    initial begin
        // R1: during reset and first cycle after release
        idle(2);
        #1 chk(1'b0, "R1", 0);
        @(negedge clk) rst_n = 1'b1;
        #1 chk(1'b0, "R1", 0);
        idle(3);

        // R2, R3, R6: kill position sweep over both polarities
        for (int s = 0; s < 2; s++) begin
            pin_sense = s[0];
            ack_pin   = ~s[0];
            idle(3);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk) data_ready = 1'b1;
                for (int n = 1; n <= 6; n++) begin
                    @(negedge clk);
                    data_ready = 1'b0;
                    if (n == k) ack_pin = s[0];
                    #1 chk((n <= 4) && (k == 0 || n < k), (k == 0) ? "R2" : "R3", n);
                end
                ack_pin = ~s[0];
                idle(3);
            end
        end

        // R4: deferred request, both polarities
        for (int s = 0; s < 2; s++) begin
            pin_sense = s[0];
            ack_pin   = ~s[0];
            idle(3);
            for (int j = 1; j <= 5; j++) begin
                @(negedge clk) data_ready = 1'b1;
                for (int n = 1; n <= 10; n++) begin
                    @(negedge clk);
                    data_ready = (n == j);
                    #1 chk(((n >= 1) && (n <= 4)) || ((n >= 6) && (n <= 9)), "R4", n);
                end
                idle(2);
            end
        end

        // R5: abort by disable, then request while disabled
        pin_sense = 1'b0;
        ack_pin   = 1'b1;
        idle(3);
        @(negedge clk) data_ready = 1'b1;
        @(negedge clk) data_ready = 1'b0;
        #1 chk(1'b1, "R5", 1);
        @(negedge clk) port_en = 1'b0;
        #1 chk(1'b0, "R5", 2);
        @(negedge clk) port_en = 1'b1;
        for (int n = 3; n <= 8; n++) begin
            #1 chk(1'b0, "R5", n);
            @(negedge clk);
        end
        port_en = 1'b0;
        data_ready = 1'b1;
        @(negedge clk) data_ready = 1'b0;
        @(negedge clk) port_en = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            #1 chk(1'b0, "R5", n);
            @(negedge clk);
        end

        // R9: line already asserted before the pulse does not shorten it
        for (int s = 0; s < 2; s++) begin
            pin_sense = s[0];
            ack_pin   = s[0];
            idle(3);
            @(negedge clk) data_ready = 1'b1;
            for (int n = 1; n <= 5; n++) begin
                @(negedge clk);
                data_ready = 1'b0;
                #1 chk(n <= 4, "R9", n);
            end
            ack_pin = ~s[0];
            idle(3);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule